// File: doc/BRIEF.md
# Retriggerable Pipelined Adder Checker

This block watches a two-stage pipelined adder that can be held by a stall input, and reports whether each addition comes out right. Whenever the adder is not stalled, a new transaction may start. The checker copies the two operands into a free tracking slot in that cycle. The transaction must then advance one stage in the next cycle. After that it may wait through any number of stall cycles. In the first cycle without stall, its result is compared with the stored operands.

Every live transaction keeps its own copy of the operands, so overlapping additions are judged separately. A slot goes back to the free pool once its transaction has ended. A transaction ends when its result is checked, or when it is abandoned because the adder stalled in the cycle right after issue. Both outputs are combinational, so a wrong sum is reported in the same cycle in which it is compared.

Top module: `adder_mon`

## Requirements
- R1: While reset is held and in the first cycle after it, no slot is live: `accept` is 1 and `overflow` is 0.
- R2: A transaction starts in every cycle with `stall` = 0, and only then. `opA` and `opB` of that cycle are recorded as its operands. Operands shown in a stall cycle are never recorded.
- R3: If `stall` is 1 in the cycle after a transaction starts, that transaction is dropped. Its result is never compared.
- R4: A transaction that survives its second cycle is compared in the first cycle with `stall` = 0 that comes at least two cycles after its start cycle. Stall cycles in between only make it wait.
- R5: In the cycle a transaction is compared, `accept` is 0 exactly when `sumOut` (WIDTH+1 bits, unsigned) differs from the zero-extended sum of its two stored operands. In every other cycle `accept` is 1.
- R6: Overlapping transactions started on consecutive non-stall cycles are each checked against their own operands.
- R7: `overflow` is 1 in exactly those cycles where a transaction would start but no slot is free. No operands are stored in such a cycle. With SLOTS of 3 or more, `overflow` never rises.
- R8: A slot becomes free in the cycle after its transaction ends, and at most one slot is taken per cycle (the lowest-numbered free one).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Stall of the observed adder |
| opA | input | WIDTH | First operand presented to the adder |
| opB | input | WIDTH | Second operand presented to the adder |
| sumOut | input | WIDTH+1 | Result output of the adder |
| accept | output | 1 | 0 in a cycle where a compared result is wrong |
| overflow | output | 1 | A transaction could not get a slot this cycle |

## Verification
A transaction started in cycle t is compared in the first non-stall cycle at t+2 or later. `accept` reflects that comparison in the same cycle, with no register between the compare and the pin. `overflow` is also combinational, and belongs to the cycle of the attempted start. The bench applies inputs shortly after each rising edge and samples the outputs two nanoseconds later, still inside the same cycle. It then advances its own model of live transactions to the next cycle, so every expected value is tied to the cycle in which the pins must show it.

// File: rtl/adder_mon_pkg.sv
package adder_mon_pkg;

  // where a tracked transaction currently sits
  typedef enum logic [1:0] {
    SLOT_IDLE    = 2'd0,
    SLOT_ISSUED  = 2'd1,
    SLOT_WAITING = 2'd2
  } slot_pos_e;

  // per-slot strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic fire;
  } slot_strobe_t;

endpackage

// File: rtl/adder_mon_ctrl.sv
module adder_mon_ctrl
  import adder_mon_pkg::*;
#(
  parameter int SLOTS = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     stall,
  output slot_strobe_t [SLOTS-1:0] strobes,
  output logic                     overflow
);

  slot_pos_e        posQ [SLOTS];
  logic [SLOTS-1:0] freeVec;
  logic [SLOTS-1:0] grant;
  logic             issueReq;
  logic             found;

  assign issueReq = !stall;

  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (issueReq && freeVec[i] && !found) begin
        grant[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  assign overflow = issueReq && !(|freeVec);

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_slot
    assign freeVec[gi]         = (posQ[gi] == SLOT_IDLE);
    assign strobes[gi].capture = grant[gi];
    assign strobes[gi].fire    = (posQ[gi] == SLOT_WAITING) && !stall;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        posQ[gi] <= SLOT_IDLE;
      end else begin
        unique case (posQ[gi])
          SLOT_IDLE:    posQ[gi] <= grant[gi] ? SLOT_ISSUED : SLOT_IDLE;
          SLOT_ISSUED:  posQ[gi] <= stall ? SLOT_IDLE : SLOT_WAITING;
          SLOT_WAITING: posQ[gi] <= stall ? SLOT_WAITING : SLOT_IDLE;
          default:      posQ[gi] <= SLOT_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/adder_mon_dp.sv
module adder_mon_dp
  import adder_mon_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SLOTS = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [WIDTH-1:0]         opA,
  input  logic [WIDTH-1:0]         opB,
  input  logic [WIDTH:0]           sumOut,
  input  slot_strobe_t [SLOTS-1:0] strobes,
  output logic [SLOTS-1:0]         errVec
);

  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] aReg [SLOTS];
  logic [WIDTH-1:0] bReg [SLOTS];

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_store
    logic [SUM_W-1:0] wantSum;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        aReg[gi] <= '0;
        bReg[gi] <= '0;
      end else if (strobes[gi].capture) begin
        aReg[gi] <= opA;
        bReg[gi] <= opB;
      end
    end

    assign wantSum     = {1'b0, aReg[gi]} + {1'b0, bReg[gi]};
    assign errVec[gi]  = strobes[gi].fire && (wantSum != sumOut);
  end

endmodule

// File: rtl/adder_mon.sv
module adder_mon
  import adder_mon_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SLOTS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stall,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [WIDTH:0]   sumOut,
  output logic             accept,
  output logic             overflow
);

  slot_strobe_t [SLOTS-1:0] strobes;
  logic [SLOTS-1:0]         errVec;
  logic [SLOTS-1:0]         captureVec;
  logic [SLOTS-1:0]         fireVec;

  adder_mon_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stall    (stall),
    .strobes  (strobes),
    .overflow (overflow)
  );

  adder_mon_dp #(.WIDTH(WIDTH), .SLOTS(SLOTS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .sumOut  (sumOut),
    .strobes (strobes),
    .errVec  (errVec)
  );

  for (genvar gi = 0; gi < SLOTS; gi++) begin : g_vec
    assign captureVec[gi] = strobes[gi].capture;
    assign fireVec[gi]    = strobes[gi].fire;
  end

  assign accept = !(|errVec);

endmodule

// File: rtl/adder_mon_chk.sv
module adder_mon_chk #(
  parameter int SLOTS = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             stall,
  input logic             accept,
  input logic             overflow,
  input logic [SLOTS-1:0] captureVec,
  input logic [SLOTS-1:0] fireVec
);

  // R2
  capture_needs_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|captureVec) |-> !stall);

  // R8
  single_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(captureVec));

  // R4
  single_terminal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(fireVec));

  // R4
  min_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|captureVec) |=> ((fireVec & $past(captureVec)) == '0));

  // R5
  flag_on_terminal_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accept |-> (|fireVec));

  // R7
  no_capture_on_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflow |-> (captureVec == '0));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (SLOTS >= 3) |-> !overflow);

endmodule

bind adder_mon adder_mon_chk #(.SLOTS(SLOTS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stall      (stall),
  .accept     (accept),
  .overflow   (overflow),
  .captureVec (captureVec),
  .fireVec    (fireVec)
);

// File: tb/test_adder_mon.sv
`timescale 1ns/1ps
module test_adder_mon;

  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             stall = 1'b1;
  logic [WIDTH-1:0] opA = '0;
  logic [WIDTH-1:0] opB = '0;
  logic [WIDTH:0]   sumOut = '0;
  logic             accept, overflow;
  logic             acceptTight, overflowTight;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state: full-size monitor
  bit             v1Valid = 0, v2Valid = 0;
  logic [WIDTH:0] v1Sum = '0, v2Sum = '0;
  // reference state: two-slot monitor occupancy
  bit             t1 = 0, t2 = 0;

  always #2.5 clk = ~clk;

  adder_mon #(.WIDTH(WIDTH), .SLOTS(3)) i_adder_mon (
    .clk(clk), .rstN(rstN), .stall(stall), .opA(opA), .opB(opB),
    .sumOut(sumOut), .accept(accept), .overflow(overflow)
  );

  adder_mon #(.WIDTH(WIDTH), .SLOTS(2)) i_adder_mon_tight (
    .clk(clk), .rstN(rstN), .stall(stall), .opA(opA), .opB(opB),
    .sumOut(sumOut), .accept(acceptTight), .overflow(overflowTight)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock cycle; inj: 0 correct result, 1 off by one, 2 carry lost
  task automatic step(input bit st, input logic [WIDTH-1:0] a,
                      input logic [WIDTH-1:0] b, input int inj, input string tag);
    bit   expAcc;
    bit   expOvfT;
    logic [WIDTH:0] s;
    @(posedge clk);
    #1;
    stall = st;
    opA   = a;
    opB   = b;
    if (v2Valid && !st) begin
      s = v2Sum;
      if (inj == 1) s = v2Sum + 1'b1;
      if (inj == 2) s = {1'b0, v2Sum[WIDTH-1:0]};
    end else begin
      s = WIDTH'($urandom);
    end
    sumOut = s;
    expAcc  = !( !st && v2Valid && (s != v2Sum) );
    expOvfT = !st && t1 && t2;
    #1;
    check(tag, accept, expAcc);
    check("R7 main overflow", overflow, 1'b0);
    check("R7/R8 tight overflow", overflowTight, expOvfT);
    if (st) begin
      v1Valid = 0;
      t1 = 0;
    end else begin
      v2Valid = v1Valid;
      v2Sum   = v1Sum;
      v1Valid = 1;
      v1Sum   = {1'b0, a} + {1'b0, b};
      t2 = t1;
      t1 = !expOvfT;
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset accept", accept, 1'b1);
    check("R1 reset overflow", overflow, 1'b0);
    check("R1 reset tight overflow", overflowTight, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    step(1, 8'd0, 8'd0, 0, "R1 first cycle accept");

    // single good add, then single bad add
    step(0, 8'd3, 8'd4, 0, "R2 issue");
    step(1, 8'd0, 8'd0, 0, "R3 kill second");
    step(0, 8'd10, 8'd20, 1, "R3 dropped not compared");
    step(0, 8'd0, 8'd0, 0, "R2 advance");
    step(0, 8'd0, 8'd0, 1, "R5 off by one flagged");
    // operands during stall are not recorded
    step(1, 8'd77, 8'd77, 0, "R2 stall no capture");
    step(1, 8'd0, 8'd0, 1, "R2 stall no compare");
    step(1, 8'd0, 8'd0, 1, "R2 stall no compare");
    // carry bit must count
    step(0, 8'd255, 8'd255, 0, "R5 issue max");
    step(0, 8'd1, 8'd1, 0, "R5 advance");
    step(0, 8'd0, 8'd0, 2, "R5 lost carry flagged");
    // long wait at the stall loop, then wrong result
    step(0, 8'd40, 8'd2, 0, "R4 issue");
    step(0, 8'd0, 8'd0, 0, "R4 advance");
    for (int i = 0; i < 6; i++) step(1, 8'd0, 8'd0, 1, "R4 waiting");
    step(0, 8'd0, 8'd0, 1, "R4 late compare flagged");
    // back-to-back issues, alternating errors
    for (int i = 0; i < 12; i++)
      step(0, WIDTH'(i * 17), WIDTH'(200 - i), i % 2, "R6 back to back");
    // random stall bursts with injected errors
    for (int i = 0; i < 3000; i++) begin
      bit st;
      st = ($urandom_range(0, 3) == 0);
      step(st, WIDTH'($urandom), WIDTH'($urandom),
           ($urandom_range(0, 3) == 0) ? int'($urandom_range(1, 2)) : 0,
           "R6 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule